// File: doc/BRIEF.md
# Accumulator Shift-Round-Saturate Unit

This block converts data between wide accumulator lanes and narrower vector lanes. On the down path, an accumulator word of eight 48-bit signed lanes is shifted right arithmetically by a programmable amount. The shifted value is rounded by the selected mode, then optionally saturated, and leaves as eight 32-bit vector lanes. On the up path, eight 32-bit vector lanes are sign-extended to 48 bits and shifted left, which produces a new accumulator word.

A small mode register holds the rounding choice and the saturation enable. Software writes it or clears it through a configuration strobe. The mode register acts only on the down path. When it is cleared, the down path truncates toward minus infinity and wraps. Both paths have two pipeline stages. A valid flag travels with each result, and one down operation and one up operation may be issued in the same cycle.

Top module: `srs_unit`

## Requirements
- R1: Down lane i takes `dn_acc[48i+47:48i]` as a signed value, shifts it right arithmetically by the shift amount, and writes the low 32 bits of the processed value to `dn_res[32i+31:32i]`.
- R2: A shift amount above 47 acts as 47 on both paths. A down shift of 0 never rounds, so the lane value goes straight to the saturation stage.
- R3: Rounding code 2'b00 (and the unused code 2'b11) truncates toward minus infinity and drops the shifted-out bits.
- R4: Rounding code 2'b01 rounds half up. It adds one when the shifted-out fraction is at least one half.
- R5: Rounding code 2'b10 rounds half to even. It adds one when the fraction is above one half, or exactly one half with an odd truncated value.
- R6: With saturation on, a rounded lane above 2^31-1 yields 32'h7FFFFFFF and a lane below -2^31 yields 32'h80000000. With saturation off, the lane keeps its low 32 bits.
- R7: When `cfg_wr` is high, it loads `cfg_rnd` and `cfg_sat` into the mode register. `cfg_clr` clears both fields and wins over `cfg_wr`. An operation issued in the same cycle as a write or clear uses the old mode.
- R8: Up lane i sign-extends `up_vec[32i+31:32i]` to 48 bits and shifts it left, then keeps the low 48 bits in `up_res[48i+47:48i]`. The mode register has no effect on this path.
- R9: Each path delivers its result two clock edges after issue, with its result-valid flag high for exactly that cycle. Both paths work independently when issued together.
- R10: After reset, the result-valid flags are low, the result buses are zero, and the mode is cleared. A result bus holds its value in cycles without a new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the mode register |
| cfg_clr | input | 1 | Clear the mode register (wins over write) |
| cfg_rnd | input | 2 | Rounding code to load |
| cfg_sat | input | 1 | Saturation enable to load |
| dn_valid | input | 1 | Issue a down operation |
| dn_shift | input | 6 | Right shift amount |
| dn_acc | input | 384 | Eight 48-bit accumulator lanes |
| up_valid | input | 1 | Issue an up operation |
| up_shift | input | 6 | Left shift amount |
| up_vec | input | 256 | Eight 32-bit vector lanes |
| dn_res_valid | output | 1 | Down result valid |
| dn_res | output | 256 | Eight 32-bit down result lanes |
| up_res_valid | output | 1 | Up result valid |
| up_res | output | 384 | Eight 48-bit up result lanes |

## Verification
Two events can fall in the same cycle: a mode write or clear, and a down issue. The bench issues an operation while writing new rounding and saturation settings. It expects the result to follow the previous mode and the next operation to follow the new one. The bench also issues up and down operations together on random cycles and checks each path against its own model. Up results are checked while every mode is active, to confirm that the mode has no effect on them.

// File: rtl/srs_pkg.sv
package srs_pkg;
    localparam int LANES = 8;
    localparam int ACC_W = 48;
    localparam int VEC_W = 32;
    localparam int SH_W  = 6;

    typedef enum logic [1:0] {
        RND_FLOOR     = 2'b00,
        RND_HALF_UP   = 2'b01,
        RND_HALF_EVEN = 2'b10,
        RND_SPARE     = 2'b11
    } rnd_e;

    typedef struct packed {
        rnd_e rnd;
        logic sat;
    } mode_t;
endpackage

// File: rtl/srs_down_lane.sv
module srs_down_lane
    import srs_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int SW = SH_W
) (
    input  logic [AW-1:0] acc,
    input  logic [SW-1:0] sh,
    input  rnd_e          rnd,
    output logic [AW:0]   rounded
);
    logic signed [AW:0] ext;
    logic signed [AW:0] trunc;
    logic [AW:0]        frac_mask;
    logic [AW:0]        below_mask;
    logic               half_bit;
    logic               sticky;
    logic               inc;

    always_comb begin
        ext        = {acc[AW-1], acc};
        trunc      = ext >>> sh;
        frac_mask  = ((AW+1)'(1) << sh) - (AW+1)'(1);
        below_mask = frac_mask >> 1;
        half_bit   = |({1'b0, acc} & frac_mask & ~below_mask);
        sticky     = |({1'b0, acc} & below_mask);
        case (rnd)
            RND_HALF_UP:   inc = half_bit;
            RND_HALF_EVEN: inc = half_bit & (sticky | trunc[0]);
            default:       inc = 1'b0;
        endcase
        rounded = trunc + (AW+1)'(inc);
    end
endmodule

// File: rtl/srs_sat_lane.sv
module srs_sat_lane
    import srs_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int VW = VEC_W
) (
    input  logic [AW:0]   val,
    input  logic          sat,
    output logic [VW-1:0] res
);
    localparam logic signed [AW:0] HI = {{(AW-VW+2){1'b0}}, {(VW-1){1'b1}}};
    localparam logic signed [AW:0] LO = {{(AW-VW+2){1'b1}}, {(VW-1){1'b0}}};
    localparam logic [VW-1:0] RES_HI = {1'b0, {(VW-1){1'b1}}};
    localparam logic [VW-1:0] RES_LO = {1'b1, {(VW-1){1'b0}}};

    always_comb begin
        if (sat && $signed(val) > HI)
            res = RES_HI;
        else if (sat && $signed(val) < LO)
            res = RES_LO;
        else
            res = val[VW-1:0];
    end
endmodule

// File: rtl/srs_up_lane.sv
module srs_up_lane
    import srs_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int VW = VEC_W,
    parameter int SW = SH_W
) (
    input  logic [VW-1:0] vec,
    input  logic [SW-1:0] sh,
    output logic [AW-1:0] res
);
    logic [AW-1:0] ext;

    always_comb begin
        ext = {{(AW-VW){vec[VW-1]}}, vec};
        res = ext << sh;
    end
endmodule

// File: rtl/srs_unit.sv
module srs_unit
    import srs_pkg::*;
#(
    parameter int NL = LANES,
    parameter int AW = ACC_W,
    parameter int VW = VEC_W,
    parameter int SW = SH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_clr,
    input  logic [1:0]       cfg_rnd,
    input  logic             cfg_sat,
    input  logic             dn_valid,
    input  logic [SW-1:0]    dn_shift,
    input  logic [NL*AW-1:0] dn_acc,
    input  logic             up_valid,
    input  logic [SW-1:0]    up_shift,
    input  logic [NL*VW-1:0] up_vec,
    output logic             dn_res_valid,
    output logic [NL*VW-1:0] dn_res,
    output logic             up_res_valid,
    output logic [NL*AW-1:0] up_res
);
    localparam int QW = AW + 1;
    localparam logic [SW-1:0] SH_MAX = SW'(AW - 1);

    typedef struct packed {
        mode_t              mode;
        logic               s1_dn_v;
        logic               s1_sat;
        logic [NL*QW-1:0]   s1_dn;
        logic               s1_up_v;
        logic [NL*AW-1:0]   s1_up;
        logic               o_dn_v;
        logic [NL*VW-1:0]   o_dn;
        logic               o_up_v;
        logic [NL*AW-1:0]   o_up;
    } state_t;

    state_t st_d, st_q;

    logic [SW-1:0]    dn_sh_eff, up_sh_eff;
    logic [NL*QW-1:0] dn_rounded;
    logic [NL*AW-1:0] up_shifted;
    logic [NL*VW-1:0] dn_final;

    assign dn_sh_eff = (dn_shift > SH_MAX) ? SH_MAX : dn_shift;
    assign up_sh_eff = (up_shift > SH_MAX) ? SH_MAX : up_shift;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        srs_down_lane #(.AW(AW), .SW(SW)) i_dn (
            .acc     (dn_acc[g*AW +: AW]),
            .sh      (dn_sh_eff),
            .rnd     (st_q.mode.rnd),
            .rounded (dn_rounded[g*QW +: QW])
        );
        srs_sat_lane #(.AW(AW), .VW(VW)) i_sat (
            .val (st_q.s1_dn[g*QW +: QW]),
            .sat (st_q.s1_sat),
            .res (dn_final[g*VW +: VW])
        );
        srs_up_lane #(.AW(AW), .VW(VW), .SW(SW)) i_up (
            .vec (up_vec[g*VW +: VW]),
            .sh  (up_sh_eff),
            .res (up_shifted[g*AW +: AW])
        );
    end

    always_comb begin
        st_d = st_q;
        if (cfg_clr)
            st_d.mode = '{rnd: RND_FLOOR, sat: 1'b0};
        else if (cfg_wr)
            st_d.mode = '{rnd: rnd_e'(cfg_rnd), sat: cfg_sat};

        st_d.s1_dn_v = dn_valid;
        if (dn_valid) begin
            st_d.s1_dn  = dn_rounded;
            st_d.s1_sat = st_q.mode.sat;
        end
        st_d.s1_up_v = up_valid;
        if (up_valid)
            st_d.s1_up = up_shifted;

        st_d.o_dn_v = st_q.s1_dn_v;
        if (st_q.s1_dn_v)
            st_d.o_dn = dn_final;
        st_d.o_up_v = st_q.s1_up_v;
        if (st_q.s1_up_v)
            st_d.o_up = st_q.s1_up;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dn_res_valid = st_q.o_dn_v;
    assign dn_res       = st_q.o_dn;
    assign up_res_valid = st_q.o_up_v;
    assign up_res       = st_q.o_up;

    a_r9_dn_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dn_valid, 2) == dn_res_valid);
    a_r9_up_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(up_valid, 2) == up_res_valid);
    a_r10_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_res_valid |-> $stable(dn_res));
    a_r10_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_res_valid |-> $stable(up_res));
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> (st_q.mode.rnd == RND_FLOOR && !st_q.mode.sat));
endmodule

// File: tb/test_srs_unit.sv
module test_srs_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0, cfg_clr = 1'b0, cfg_sat = 1'b0;
    logic [1:0]   cfg_rnd = 2'b00;
    logic         dn_valid = 1'b0, up_valid = 1'b0;
    logic [5:0]   dn_shift = '0, up_shift = '0;
    logic [383:0] dn_acc = '0;
    logic [255:0] up_vec = '0;
    logic         dn_res_valid, up_res_valid;
    logic [255:0] dn_res;
    logic [383:0] up_res;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [1:0] m_rnd = 2'b00;
    logic       m_sat = 1'b0;

    logic         pv_dn [2];
    logic [255:0] pe_dn [2];
    string        pt_dn [2];
    logic         pv_up [2];
    logic [383:0] pe_up [2];
    string        pt_up [2];
    logic [255:0] last_dn = '0;
    logic [383:0] last_up = '0;

    srs_unit i_srs_unit (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] lane_dn(logic [47:0] a, int s, logic [1:0] rnd, logic sat);
        longint x, q, r, h;
        int e;
        e = (s > 47) ? 47 : s;
        x = {{16{a[47]}}, a};
        q = x >>> e;
        r = x - (q <<< e);
        h = (e == 0) ? 0 : (64'sd1 <<< (e - 1));
        if (e != 0) begin
            if (rnd == 2'b01 && r >= h) q = q + 1;
            if (rnd == 2'b10 && (r > h || (r == h && q[0]))) q = q + 1;
        end
        if (sat && q > 64'sd2147483647) return 32'h7FFFFFFF;
        if (sat && q < -64'sd2147483648) return 32'h80000000;
        return q[31:0];
    endfunction

    function automatic logic [255:0] model_dn(logic [383:0] a, int s, logic [1:0] rnd, logic sat);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = lane_dn(a[i*48 +: 48], s, rnd, sat);
        return r;
    endfunction

    function automatic logic [383:0] model_up(logic [255:0] v, int s);
        logic [383:0] r;
        longint x;
        int e;
        e = (s > 47) ? 47 : s;
        for (int i = 0; i < 8; i++) begin
            x = {{32{v[i*32+31]}}, v[i*32 +: 32]};
            x = x <<< e;
            r[i*48 +: 48] = x[47:0];
        end
        return r;
    endfunction

    function automatic logic [383:0] rep48(longint v);
        logic [383:0] r;
        for (int i = 0; i < 8; i++) r[i*48 +: 48] = v[47:0];
        return r;
    endfunction

    function automatic logic [255:0] rep32(longint v);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[i*32 +: 32] = v[31:0];
        return r;
    endfunction

    task automatic chk(string tag, logic [383:0] got, logic [383:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input bit dv, input logic [383:0] da, input int ds,
                        input bit uv, input logic [255:0] uvv, input int us,
                        input bit cw, input bit cc, input logic [1:0] cr, input bit cs,
                        input string dtag, input string utag);
        chk({pt_dn[1], " dn valid"}, 384'(dn_res_valid), 384'(pv_dn[1]));
        chk({pt_dn[1], " dn data"}, 384'(dn_res), 384'(pv_dn[1] ? pe_dn[1] : last_dn));
        chk({pt_up[1], " up valid"}, 384'(up_res_valid), 384'(pv_up[1]));
        chk({pt_up[1], " up data"}, up_res, pv_up[1] ? pe_up[1] : last_up);
        if (pv_dn[1]) last_dn = pe_dn[1];
        if (pv_up[1]) last_up = pe_up[1];
        pv_dn[1] = pv_dn[0]; pe_dn[1] = pe_dn[0]; pt_dn[1] = pt_dn[0];
        pv_up[1] = pv_up[0]; pe_up[1] = pe_up[0]; pt_up[1] = pt_up[0];
        pv_dn[0] = dv; pe_dn[0] = model_dn(da, ds, m_rnd, m_sat); pt_dn[0] = dtag;
        pv_up[0] = uv; pe_up[0] = model_up(uvv, us); pt_up[0] = utag;
        dn_valid = dv; dn_acc = da; dn_shift = 6'(ds);
        up_valid = uv; up_vec = uvv; up_shift = 6'(us);
        cfg_wr = cw; cfg_clr = cc; cfg_rnd = cr; cfg_sat = cs;
        if (cc) begin m_rnd = 2'b00; m_sat = 1'b0; end
        else if (cw) begin m_rnd = cr; m_sat = cs; end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, 0, 0, 0, 2'b00, 0, "R10", "R10");
    endtask

    task automatic dn1(logic [383:0] a, int s, string tag);
        step(1, a, s, 0, '0, 0, 0, 0, 2'b00, 0, tag, "R9");
    endtask

    task automatic setmode(logic [1:0] r, bit s);
        step(0, '0, 0, 0, '0, 0, 1, 0, r, s, "R7", "R7");
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            pv_dn[i] = 0; pe_dn[i] = '0; pt_dn[i] = "R10";
            pv_up[i] = 0; pe_up[i] = '0; pt_up[i] = "R10";
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset dn valid", 384'(dn_res_valid), '0);
        chk("R10 reset dn data", 384'(dn_res), '0);
        chk("R10 reset up data", up_res, '0);
        idle(2);

        // R3 floor: 5>>1=2, -5>>1=-3
        dn1(rep48(5), 1, "R3 floor pos");
        dn1(rep48(-5), 1, "R3 floor neg");
        setmode(2'b11, 0);
        dn1(rep48(-7), 2, "R3 spare code floors");
        // R4 half up: 2.5->3, -2.5->-2
        setmode(2'b01, 0);
        dn1(rep48(5), 1, "R4 half up pos");
        dn1(rep48(-5), 1, "R4 half up neg");
        dn1(rep48(-6), 2, "R4 below half");
        // R5 half even
        setmode(2'b10, 0);
        dn1(rep48(5), 1, "R5 even 2.5");
        dn1(rep48(7), 1, "R5 even 3.5");
        dn1(rep48(-5), 1, "R5 even -2.5");
        dn1(rep48(13), 3, "R5 above half");
        // R2 shift clamp and zero shift
        dn1(rep48(-64'sd140737488355328), 60, "R2 clamp 60");
        dn1(rep48(64'sd70368744177664), 47, "R2 shift 47");
        dn1(rep48(-9), 0, "R2 zero shift");
        // R6 saturation
        setmode(2'b00, 1);
        dn1(rep48(64'sd1099511627776), 0, "R6 sat high");
        dn1(rep48(-64'sd1099511627776), 4, "R6 sat low");
        dn1(rep48(64'sd2147483647), 0, "R6 at limit");
        setmode(2'b00, 0);
        dn1(rep48(64'sd1099511627781), 0, "R6 wrap");
        // R7 same-cycle write and issue: old mode applies, then new
        step(1, rep48(5), 1, 0, '0, 0, 1, 0, 2'b01, 1, "R7 old mode", "R7");
        dn1(rep48(5), 1, "R7 new mode");
        step(1, rep48(64'sd1099511627776), 0, 0, '0, 0, 1, 1, 2'b10, 1, "R7 clr wins issue", "R7");
        dn1(rep48(64'sd1099511627776), 0, "R7 cleared wraps");
        dn1(rep48(7), 1, "R7 cleared floors");
        // R8 up path under every mode, with clamp
        setmode(2'b01, 1);
        step(0, '0, 0, 1, rep32(-3), 4, 0, 0, 2'b00, 0, "R8", "R8 up neg");
        step(0, '0, 0, 1, rep32(32'h7FFFFFFF), 20, 0, 0, 2'b00, 0, "R8", "R8 up wrap");
        step(0, '0, 0, 1, rep32(1), 63, 0, 0, 2'b00, 0, "R8", "R8 up clamp");
        // R9 both paths together, back to back
        step(1, rep48(-1000), 3, 1, rep32(77), 2, 0, 0, 2'b00, 0, "R9 dual dn", "R9 dual up");
        step(1, rep48(999), 2, 1, rep32(-77), 5, 0, 0, 2'b00, 0, "R9 dual dn", "R9 dual up");
        idle(3);

        // R1 random: mixed lanes, modes, shifts, concurrent issues
        for (int n = 0; n < 3000; n++) begin
            logic [383:0] a;
            logic [255:0] v;
            for (int i = 0; i < 12; i++) a[i*32 +: 32] = $urandom;
            for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
            if ($urandom % 3 == 0)
                for (int i = 0; i < 8; i++) a[i*48 +: 48] = {{16{a[i*48+31]}}, a[i*48 +: 32]};
            step($urandom % 4 != 0, a, $urandom % 64, $urandom % 2 == 0, v, $urandom % 64,
                 $urandom % 8 == 0, $urandom % 32 == 0, 2'($urandom), 1'($urandom),
                 "R1 random dn", "R8 random up");
        end
        idle(3);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule